// File: doc/BRIEF.md
# Panel Register Write Sequencer over SPI

This block turns one host request, made of an 8-bit register index and a 16-bit value, into a complete register write to a display controller on a serial bus. The block is the bus master. It sends two separate chip-select transactions of 24 bits each. The first transaction carries a fixed index tag, a zero byte and the register index. The second carries a fixed data tag and the value, high byte first. Between the two transactions, chip select goes high.

The bus uses clock-idle-high timing. Data is sampled on the rising clock edge, and the block changes data only while the clock is low. A parameter sets the half-period of the serial clock as a number of system clocks. An elaboration check keeps the serial clock at or below its rated maximum of 20 MHz. On the host side, the block accepts a request through a valid/busy pair. It reports completion with a single-cycle done pulse. Typical writes are to the panel's power register (index 0x11, bit 0 set for shutdown, bit 0 clear for on) and to its scan/colour-order register (index 0x01). The block does not interpret these values.

Top module: `panel_spi_writer`

## Requirements
- R1: The first transaction of a write carries the 24-bit word {0x74, 0x00, index}.
- R2: The second transaction carries the 24-bit word {0x76, value[15:8], value[7:0]}.
- R3: Bits are sent most significant first. MOSI changes only at a falling SCK edge or while chip select is high, and it holds steady across every rising SCK edge. MOSI is 0 while chip select is high.
- R4: Chip select is active low. Each transaction has exactly 24 rising SCK edges inside one low period of chip select. Between the two transactions, chip select stays high for GAP_HALVES half periods. GAP_HALVES is at least 2, so the gap is at least one full SCK period. Chip select is high whenever the block is idle.
- R5: SCK idles high, and every SCK level lasts HALF_DIV system clocks. The first falling edge of a transaction comes one half period after chip select falls. Chip select rises one half period after the last rising edge.
- R6: A request is accepted on a clock edge where req_valid is high and busy is low. Busy is high from the following cycle onward. req_valid is ignored while busy is high.
- R7: Busy stays high until the last half period of the second transaction ends. Busy then falls, and done is high for exactly that one cycle, with chip select already high.
- R8: spi_miso has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request strobe |
| req_index | input | IDX_W (8) | Panel register index |
| req_value | input | VAL_W (16) | Value to write |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to panel |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data from panel, unused |

## Verification
A wrong state in the sequencer shows up on the pins within one half period. Examples are a misplaced half-period count, a stale frame select, or a shift register that advances at the wrong step. The cycle-exact reference compares chip select, SCK, MOSI, busy and done on every clock, so the first wrong cycle fails at once. A separate bus monitor captures bits on rising SCK edges and checks each transaction's length and word when chip select rises. Errors in bit order or tag bytes are therefore also reported per frame. Continuous requests, requests made while busy, and a toggling MISO line exercise the paths where state leaks.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;

   localparam int FRAME_BITS = 24;
   localparam int BYTE_BITS  = 8;

   // half periods inside one chip-select low window: setup + two per bit
   localparam int FRAME_HALVES = 2 * FRAME_BITS + 1;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FRAME = 2'd1,
      SEQ_GAP   = 2'd2
   } seq_state_t;

   // panel register indices and field bits commonly written through this block
   localparam logic [7:0] PNL_REG_POWER   = 8'h11;
   localparam logic [7:0] PNL_REG_SCAN    = 8'h01;
   localparam int         PNL_POWER_OFF_B = 0;
   localparam int         PNL_SCAN_LR_B   = 8;
   localparam int         PNL_SCAN_TB_B   = 9;
   localparam int         PNL_SCAN_BGR_B  = 11;
   localparam int         PNL_SCAN_NORM_B = 13;

   function automatic logic [FRAME_BITS-1:0] pack_frame(
      input logic [BYTE_BITS-1:0] tag,
      input logic [BYTE_BITS-1:0] mid,
      input logic [BYTE_BITS-1:0] low);
      return {tag, mid, low};
   endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
   parameter int HALF_DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);

   generate
      if (HALF_DIV == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;

         assign tick = run && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart || !run || tick) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
   import panel_spi_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] load_word,
   input  logic                  step,
   input  logic                  clear,
   output logic                  sck,
   output logic                  mosi
);

   logic [FRAME_BITS-1:0] shreg_q;
   logic                  primed_q;
   logic                  sck_q;
   logic                  mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         primed_q <= 1'b0;
         sck_q    <= 1'b1;
         mosi_q   <= 1'b0;
      end else if (load) begin
         shreg_q  <= load_word;
         primed_q <= 1'b0;
         sck_q    <= 1'b1;
         mosi_q   <= load_word[FRAME_BITS-1];
      end else if (clear) begin
         sck_q    <= 1'b1;
         mosi_q   <= 1'b0;
      end else if (step) begin
         if (sck_q) begin
            // falling edge: advance to the next bit except on the first one
            sck_q    <= 1'b0;
            primed_q <= 1'b1;
            if (primed_q) begin
               mosi_q  <= shreg_q[FRAME_BITS-2];
               shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
            end
         end else begin
            sck_q <= 1'b1;
         end
      end
   end

   assign sck  = sck_q;
   assign mosi = mosi_q;

endmodule

// File: rtl/panel_write_seq.sv
module panel_write_seq
   import panel_spi_pkg::*;
#(
   parameter int             GAP_HALVES = 2,
   parameter logic [7:0]     INDEX_TAG  = 8'h74,
   parameter logic [7:0]     DATA_TAG   = 8'h76
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [7:0]            req_index,
   input  logic [15:0]           req_value,
   input  logic                  tick,
   output logic                  busy,
   output logic                  done,
   output logic                  cs_n,
   output logic                  accept,
   output logic                  load,
   output logic [FRAME_BITS-1:0] load_word,
   output logic                  step,
   output logic                  clear
);

   localparam int HMAX = (FRAME_HALVES > GAP_HALVES) ? FRAME_HALVES : GAP_HALVES;
   localparam int HW   = $clog2(HMAX + 1);
   localparam logic [HW-1:0] FRAME_LAST = HW'(FRAME_HALVES - 1);
   localparam logic [HW-1:0] GAP_LAST   = HW'(GAP_HALVES - 1);

   seq_state_t            state_q;
   logic [HW-1:0]         hcnt_q;
   logic                  second_q;
   logic                  busy_q;
   logic                  done_q;
   logic                  cs_n_q;
   logic [FRAME_BITS-1:0] data_word_q;
   logic                  gap_end;
   logic                  frame_end;

   assign accept    = req_valid && !busy_q;
   assign gap_end   = (state_q == SEQ_GAP)   && tick && (hcnt_q == GAP_LAST);
   assign frame_end = (state_q == SEQ_FRAME) && tick && (hcnt_q == FRAME_LAST);
   assign step      = (state_q == SEQ_FRAME) && tick && (hcnt_q != FRAME_LAST);
   assign clear     = frame_end;
   assign load      = accept || gap_end;
   assign load_word = accept ? pack_frame(INDEX_TAG, 8'h00, req_index) : data_word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SEQ_IDLE;
         hcnt_q      <= '0;
         second_q    <= 1'b0;
         busy_q      <= 1'b0;
         done_q      <= 1'b0;
         cs_n_q      <= 1'b1;
         data_word_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  state_q     <= SEQ_FRAME;
                  hcnt_q      <= '0;
                  second_q    <= 1'b0;
                  busy_q      <= 1'b1;
                  cs_n_q      <= 1'b0;
                  data_word_q <= pack_frame(DATA_TAG, req_value[15:8], req_value[7:0]);
               end
            end
            SEQ_FRAME: begin
               if (frame_end) begin
                  cs_n_q <= 1'b1;
                  hcnt_q <= '0;
                  if (second_q) begin
                     state_q <= SEQ_IDLE;
                     busy_q  <= 1'b0;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= SEQ_GAP;
                  end
               end else if (tick) begin
                  hcnt_q <= hcnt_q + 1'b1;
               end
            end
            SEQ_GAP: begin
               if (gap_end) begin
                  state_q  <= SEQ_FRAME;
                  second_q <= 1'b1;
                  cs_n_q   <= 1'b0;
                  hcnt_q   <= '0;
               end else if (tick) begin
                  hcnt_q <= hcnt_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign cs_n = cs_n_q;

endmodule

// File: rtl/panel_spi_writer.sv
module panel_spi_writer
   import panel_spi_pkg::*;
#(
   parameter int         CLK_HZ     = 200_000_000,
   parameter int         SCK_MAX_HZ = 20_000_000,
   parameter int         HALF_DIV   = 5,
   parameter int         GAP_HALVES = 2,
   parameter int         IDX_W      = 8,
   parameter int         VAL_W      = 16,
   parameter logic [7:0] INDEX_TAG  = 8'h74,
   parameter logic [7:0] DATA_TAG   = 8'h76
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [IDX_W-1:0] req_index,
   input  logic [VAL_W-1:0] req_value,
   output logic             busy,
   output logic             done,
   output logic             spi_sck,
   output logic             spi_mosi,
   output logic             spi_cs_n,
   input  logic             spi_miso
);

   localparam longint SCK_HZ = longint'(CLK_HZ) / (2 * longint'(HALF_DIV));

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (SCK_HZ > longint'(SCK_MAX_HZ)) begin : g_too_fast
         $error("serial clock exceeds SCK_MAX_HZ");
      end
      if (GAP_HALVES < 2) begin : g_bad_gap
         $error("GAP_HALVES must cover at least one serial clock period");
      end
      if (IDX_W != BYTE_BITS || VAL_W != 2 * BYTE_BITS) begin : g_bad_width
         $error("index must be one byte and value two bytes");
      end
   endgenerate

   logic                  tick;
   logic                  accept;
   logic                  load;
   logic [FRAME_BITS-1:0] load_word;
   logic                  step;
   logic                  clear;
   logic                  miso_unused;

   assign miso_unused = spi_miso;

   spi_half_tick #(
      .HALF_DIV (HALF_DIV)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (accept),
      .tick    (tick)
   );

   panel_write_seq #(
      .GAP_HALVES (GAP_HALVES),
      .INDEX_TAG  (INDEX_TAG),
      .DATA_TAG   (DATA_TAG)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_index (req_index[7:0]),
      .req_value (req_value[15:0]),
      .tick      (tick),
      .busy      (busy),
      .done      (done),
      .cs_n      (spi_cs_n),
      .accept    (accept),
      .load      (load),
      .load_word (load_word),
      .step      (step),
      .clear     (clear)
   );

   spi_frame_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_word (load_word),
      .step      (step),
      .clear     (clear),
      .sck       (spi_sck),
      .mosi      (spi_mosi)
   );

endmodule

// File: rtl/panel_spi_writer_chk.sv
module panel_spi_writer_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic done,
   input logic spi_sck,
   input logic spi_mosi,
   input logic spi_cs_n
);

   // R4: chip select released whenever no write is running
   assert_cs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n);

   // R5: clock parked high outside a transaction
   assert_sck_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> spi_sck);

   // R5: falling clock edges only with chip select low
   assert_fall_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_sck) |-> !spi_cs_n);

   // R3: data steady across every rising clock edge
   assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck) |-> $stable(spi_mosi));

   // R3: data line low while deselected
   assert_mosi_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_mosi);

   // R6: accepted request raises busy
   assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   // R7: done lasts a single cycle
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: done coincides with the fall of busy
   assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($fell(busy) && spi_cs_n));

endmodule

bind panel_spi_writer panel_spi_writer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .spi_sck   (spi_sck),
   .spi_mosi  (spi_mosi),
   .spi_cs_n  (spi_cs_n)
);

// File: tb/sim_panel_spi_writer.sv
`timescale 1ns/100ps
module sim_panel_spi_writer;
   import panel_spi_pkg::*;

   localparam int D   = 5;
   localparam int G   = 2;
   localparam int FH  = 2 * 24 + 1;
   localparam int TD  = (2 * FH + G) * D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_index = '0;
   logic [15:0] req_value = '0;
   logic        spi_miso = 1'b0;
   logic        busy, done, spi_sck, spi_mosi, spi_cs_n;

   integer n_checks = 0;
   integer n_fail   = 0;
   integer cycles   = 0;

   always #2.5 clk = ~clk;

   panel_spi_writer #(
      .HALF_DIV   (D),
      .GAP_HALVES (G)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_index (req_index),
      .req_value (req_value),
      .busy      (busy),
      .done      (done),
      .spi_sck   (spi_sck),
      .spi_mosi  (spi_mosi),
      .spi_cs_n  (spi_cs_n),
      .spi_miso  (spi_miso)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks = n_checks + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                  req, what, act, exp, cycles);
      end
   endtask

   // behavioural reference: age counts edges since the accepting edge
   integer      age = -1;
   logic [23:0] m_f0, m_f1;
   logic [23:0] exp_q[$];
   integer      accepts = 0;

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (!rst_n) begin
         age = -1;
      end else if (age < 0 || age == TD) begin
         if (req_valid) begin
            age  = 0;
            m_f0 = {8'h74, 8'h00, req_index};
            m_f1 = {8'h76, req_value};
            exp_q.push_back(m_f0);
            exp_q.push_back(m_f1);
            accepts = accepts + 1;
         end else begin
            age = -1;
         end
      end else begin
         age = age + 1;
      end
   end

   always @(negedge clk) begin
      logic e_busy, e_done, e_cs, e_sck, e_mosi;
      integer h, l, k;
      logic [23:0] f;
      e_busy = 0; e_done = 0; e_cs = 1; e_sck = 1; e_mosi = 0;
      if (rst_n && age >= 0) begin
         if (age == TD) begin
            e_done = 1;
         end else begin
            e_busy = 1;
            h = age / D;
            if (h < FH || h >= FH + G) begin
               f = (h < FH) ? m_f0 : m_f1;
               l = (h < FH) ? h : h - FH - G;
               e_cs = 0;
               if (l == 0)          begin e_sck = 1; k = 0;           end
               else if (l % 2 == 1) begin e_sck = 0; k = (l - 1) / 2; end
               else                 begin e_sck = 1; k = (l - 2) / 2; end
               e_mosi = f[23 - k];
            end
         end
      end
      chk(busy == e_busy, "R6", "busy", busy, e_busy);
      chk(done == e_done, "R7", "done", done, e_done);
      chk(spi_cs_n == e_cs, "R4", "cs_n", spi_cs_n, e_cs);
      chk(spi_sck == e_sck, "R5", "sck", spi_sck, e_sck);
      chk(spi_mosi == e_mosi, "R3", "mosi", spi_mosi, e_mosi);
   end

   // bus monitor: captures on rising SCK, judges each frame at chip-select rise
   logic [23:0] mon_word = '0;
   integer      mon_bits = 0;

   always @(negedge spi_cs_n) begin
      mon_bits = 0;
      mon_word = '0;
   end

   always @(posedge spi_sck) begin
      if (!spi_cs_n) begin
         mon_word = {mon_word[22:0], spi_mosi};
         mon_bits = mon_bits + 1;
      end
   end

   always @(posedge spi_cs_n) begin
      if (rst_n) begin
         logic [23:0] want;
         want = (exp_q.size() > 0) ? exp_q.pop_front() : 24'hxxxxxx;
         chk(mon_bits == 24, "R4", "bits per frame", mon_bits, 24);
         if (want[23:16] == 8'h74)
            chk(mon_word == want, "R1", "index frame", mon_word, want);
         else
            chk(mon_word == want, "R2", "data frame", mon_word, want);
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic write_reg(input logic [7:0] idx, input logic [15:0] val);
      @(negedge clk);
      req_index = idx;
      req_value = val;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_index = 8'hxx === 8'h00 ? 8'h00 : ~idx;  // scramble after acceptance
      req_value = ~val;
      wait_idle();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      integer a0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(busy == 0 && done == 0, "R7", "reset busy/done", {busy, done}, 0);
      chk(spi_cs_n == 1 && spi_sck == 1 && spi_mosi == 0, "R4", "reset pins",
          {spi_cs_n, spi_sck, spi_mosi}, 3'b110);

      // power register: on, then shutdown (bit 0 set)
      write_reg(PNL_REG_POWER, 16'h0000);
      write_reg(PNL_REG_POWER, 16'h0001 << PNL_POWER_OFF_B);
      // scan register with scan and colour-order fields
      write_reg(PNL_REG_SCAN, (16'h1 << PNL_SCAN_LR_B) | (16'h1 << PNL_SCAN_TB_B) |
                              (16'h1 << PNL_SCAN_BGR_B) | (16'h1 << PNL_SCAN_NORM_B) | 16'h00EF);
      // extremes of the bit patterns
      write_reg(8'hFF, 16'hFFFF);
      write_reg(8'hA5, 16'h5AC3);

      // R8: MISO toggles throughout a write
      fork
         begin
            repeat (600) begin
               @(negedge clk);
               spi_miso = $urandom_range(0, 1);
            end
         end
         write_reg(8'h3C, 16'h8001);
      join
      spi_miso = 1'b0;
      chk(exp_q.size() == 0, "R8", "frames pending after toggling miso", exp_q.size(), 0);

      // R6: requests while busy are ignored
      a0 = accepts;
      @(negedge clk);
      req_index = 8'h12; req_value = 16'h3456; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (40) begin
         @(negedge clk);
         req_valid = 1'b1; req_index = 8'hEE; req_value = 16'hDDDD;
         @(negedge clk);
         req_valid = 1'b0;
      end
      wait_idle();
      chk(accepts == a0 + 1, "R6", "accepts while busy", accepts, a0 + 1);

      // R7: request held high is accepted again in the done cycle
      a0 = accepts;
      @(negedge clk);
      req_index = 8'h01; req_value = 16'hC3C3; req_valid = 1'b1;
      while (!done) @(negedge clk);
      chk(busy == 0, "R7", "busy low with done", busy, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1, "R6", "back-to-back accept", busy, 1);
      wait_idle();
      chk(accepts == a0 + 2, "R7", "back-to-back count", accepts, a0 + 2);

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R2", "all frames seen", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule